// File: doc/BRIEF.md
# Dual-Pipe Instruction Issue Steering

This block sits between an instruction fetch buffer and two execution pipes. Each cycle it looks at the two oldest decoded instructions, which arrive in program order as an older slot and a younger slot. Each instruction carries a class code, and the class code alone decides which pipe the instruction needs. The even pipe runs multiplies, fixed-point arithmetic, logical operations and word shifts. The odd pipe runs permutes, shuffles, quadword rotates, branches, local-store loads and stores, and channel accesses.

Issue is strictly in order. When the pair splits so that one instruction goes to each pipe, both issue together. When both need the same pipe, only the older one issues and the younger one waits. The younger slot never issues on its own. A combinational count of 0, 1 or 2 tells the fetch buffer how far to advance in the same cycle, so that a held younger instruction becomes the older slot on the next cycle. The per-pipe issue strobes, and the class code that goes with each, are registered into the pipe entry stage and appear one clock later.

Top module: `dual_pipe_steer`

## Requirements
- R1: Class codes 0 to 3 (multiply, fixed-point arithmetic, logical, word shift) are steered to the even pipe.
- R2: Class codes 4 to 15 are steered to the odd pipe. Codes 4 to 9 are permute, shuffle, quadword rotate, branch, local-store access and channel access. Codes 10 to 15 are reserved and also go to the odd pipe.
- R3: With `pipes_rdy` high, both slots valid, and the two slots on different pipes, both instructions issue, `take_cnt` is 2, and each pipe receives the class code of the slot steered to it.
- R4: With `pipes_rdy` high, both slots valid, and both slots on the same pipe, only the older slot issues and `take_cnt` is 1.
- R5: While `pipes_rdy` is low, `take_cnt` is 0 and neither issue strobe is raised on the following cycle, whatever the slots hold.
- R6: When the older slot is not valid, nothing issues and `take_cnt` is 0, even if the younger slot is valid.
- R7: With `pipes_rdy` high, the older slot valid and the younger slot not valid, the older instruction issues alone and `take_cnt` is 1.
- R8: `take_cnt` is combinational in the cycle the pair is presented. `even_fire`, `odd_fire`, `even_cls` and `odd_cls` show that decision on the next cycle. A class output is 0 whenever its strobe is low.
- R9: While `rst_n` is low, and on the first cycle after it rises, both strobes are low and both class outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op0_vld | input | 1 | Older slot holds an instruction |
| op0_cls | input | 4 | Older slot class code |
| op1_vld | input | 1 | Younger slot holds an instruction |
| op1_cls | input | 4 | Younger slot class code |
| pipes_rdy | input | 1 | Downstream pipes can accept issue this cycle |
| take_cnt | output | 2 | Instructions consumed this cycle (0, 1 or 2) |
| even_fire | output | 1 | Registered issue strobe for the even pipe |
| even_cls | output | 4 | Class code issued to the even pipe |
| odd_fire | output | 1 | Registered issue strobe for the odd pipe |
| odd_cls | output | 4 | Class code issued to the odd pipe |

## Verification
`take_cnt` is due in the same cycle as the pair it describes. The bench reads it one nanosecond after it drives the inputs on the falling edge. The strobes and class outputs are due one rising edge later. For every pair it presents, the driver queues the expected pipe-side result. A monitor pops that result and compares it with the outputs halfway through the high phase after the next rising edge, so each check compares one decision with the registered cycle that reports it.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int CLS_W      = 4;
  localparam int EVEN_CODES = 4;
  localparam int SLOTS      = 2;
  localparam int CNT_W      = $clog2(SLOTS + 1);

  typedef enum logic {PIPE_EVEN = 1'b0, PIPE_ODD = 1'b1} pipe_e;

  function automatic pipe_e pipe_of(input logic [CLS_W-1:0] cls);
    return (int'(cls) < EVEN_CODES) ? PIPE_EVEN : PIPE_ODD;
  endfunction

  function automatic logic [CNT_W-1:0] count_of(input logic t0, input logic t1);
    return CNT_W'(t0) + CNT_W'(t1);
  endfunction
endpackage

// File: rtl/steer_classify.sv
module steer_classify
  import steer_pkg::*;
(
  input  logic [CLS_W-1:0] cls [SLOTS],
  output pipe_e            pipe [SLOTS]
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign pipe[s] = pipe_of(cls[s]);
  end
endmodule

// File: rtl/steer_decide.sv
module steer_decide
  import steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld  [SLOTS],
  input  pipe_e            pipe [SLOTS],
  input  logic             rdy,
  output logic             take [SLOTS],
  output logic [CNT_W-1:0] cnt
);
  logic older_go;
  logic split_pair;

  assign older_go   = rdy && vld[0];
  assign split_pair = vld[1] && (pipe[0] != pipe[1]);
  assign take[0]    = older_go;
  assign take[1]    = older_go && split_pair;
  assign cnt        = count_of(take[0], take[1]);

  // R5: a stalled downstream consumes nothing
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> cnt == '0);
  // R6: the younger slot never issues ahead of the older one
  p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld[0] |-> cnt == '0);
  // R4: a same-pipe pair consumes exactly one
  p_conflict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && vld[0] && vld[1] && pipe[0] == pipe[1]) |-> cnt == CNT_W'(1));
  // R3: a split pair consumes two
  p_dual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && vld[0] && vld[1] && pipe[0] != pipe[1]) |-> cnt == CNT_W'(2));
endmodule

// File: rtl/steer_issue_reg.sv
module steer_issue_reg
  import steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take [SLOTS],
  input  pipe_e            pipe [SLOTS],
  input  logic [CLS_W-1:0] cls  [SLOTS],
  output logic             even_fire,
  output logic [CLS_W-1:0] even_cls,
  output logic             odd_fire,
  output logic [CLS_W-1:0] odd_cls
);
  logic             even_hit [SLOTS];
  logic             odd_hit  [SLOTS];
  logic             even_d, odd_d;
  logic [CLS_W-1:0] even_cls_d, odd_cls_d;

  for (genvar s = 0; s < SLOTS; s++) begin : g_hit
    assign even_hit[s] = take[s] && (pipe[s] == PIPE_EVEN);
    assign odd_hit[s]  = take[s] && (pipe[s] == PIPE_ODD);
  end

  always_comb begin
    even_d = 1'b0; odd_d = 1'b0;
    even_cls_d = '0; odd_cls_d = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (even_hit[s]) begin even_d = 1'b1; even_cls_d = cls[s]; end
      if (odd_hit[s])  begin odd_d  = 1'b1; odd_cls_d  = cls[s]; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      even_fire <= 1'b0; odd_fire <= 1'b0;
      even_cls  <= '0;   odd_cls  <= '0;
    end else begin
      even_fire <= even_d; odd_fire <= odd_d;
      even_cls  <= even_cls_d; odd_cls <= odd_cls_d;
    end
  end

  // R8: an idle pipe carries a zero class code
  p_quiet_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !even_fire |-> even_cls == '0);
  p_quiet_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !odd_fire |-> odd_cls == '0);
  // R1: whatever fires on the even pipe is an even class
  p_even_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    even_fire |-> int'(even_cls) < EVEN_CODES);
  // R2: whatever fires on the odd pipe is an odd class
  p_odd_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    odd_fire |-> int'(odd_cls) >= EVEN_CODES);
endmodule

// File: rtl/dual_pipe_steer.sv
module dual_pipe_steer
  import steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op0_vld,
  input  logic [CLS_W-1:0] op0_cls,
  input  logic             op1_vld,
  input  logic [CLS_W-1:0] op1_cls,
  input  logic             pipes_rdy,
  output logic [CNT_W-1:0] take_cnt,
  output logic             even_fire,
  output logic [CLS_W-1:0] even_cls,
  output logic             odd_fire,
  output logic [CLS_W-1:0] odd_cls
);
  logic [CLS_W-1:0] slot_cls  [SLOTS];
  logic             slot_vld  [SLOTS];
  pipe_e            slot_pipe [SLOTS];
  logic             slot_take [SLOTS];
  logic             rst_seen;

  assign slot_cls[0] = op0_cls;
  assign slot_cls[1] = op1_cls;
  assign slot_vld[0] = op0_vld;
  assign slot_vld[1] = op1_vld;

  steer_classify u_classify (.cls(slot_cls), .pipe(slot_pipe));

  steer_decide u_decide (
    .clk(clk), .rst_n(rst_n), .vld(slot_vld), .pipe(slot_pipe),
    .rdy(pipes_rdy), .take(slot_take), .cnt(take_cnt));

  steer_issue_reg u_issue (
    .clk(clk), .rst_n(rst_n), .take(slot_take), .pipe(slot_pipe),
    .cls(slot_cls), .even_fire(even_fire), .even_cls(even_cls),
    .odd_fire(odd_fire), .odd_cls(odd_cls));

  always_ff @(posedge clk) begin
    if (!rst_n) rst_seen <= 1'b0;
    else        rst_seen <= 1'b1;
  end

  // R8: the strobes one cycle later account for exactly what was consumed
  p_fire_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen |-> $countones({even_fire, odd_fire}) == int'($past(take_cnt)));
  // R5: a stall cycle is followed by no issue
  p_stall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pipes_rdy |=> !even_fire && !odd_fire);
endmodule

// File: tb/tb_dual_pipe_steer.sv
module tb_dual_pipe_steer;
  typedef struct {
    logic       ef;
    logic [3:0] ec;
    logic       of;
    logic [3:0] oc;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op0_vld = 1'b0, op1_vld = 1'b0, pipes_rdy = 1'b0;
  logic [3:0] op0_cls = '0, op1_cls = '0;
  logic [1:0] take_cnt;
  logic       even_fire, odd_fire;
  logic [3:0] even_cls, odd_cls;

  int   n_chk = 0, n_bad = 0;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  dual_pipe_steer dut (
    .clk(clk), .rst_n(rst_n), .op0_vld(op0_vld), .op0_cls(op0_cls),
    .op1_vld(op1_vld), .op1_cls(op1_cls), .pipes_rdy(pipes_rdy),
    .take_cnt(take_cnt), .even_fire(even_fire), .even_cls(even_cls),
    .odd_fire(odd_fire), .odd_cls(odd_cls));

  function automatic bit is_odd(input logic [3:0] c);
    return c > 4'd3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: present a pair, check the count at once, queue the pipe result
  task automatic apply(input logic v0, input logic [3:0] c0,
                       input logic v1, input logic [3:0] c1,
                       input logic rdy, input string tag);
    exp_t e;
    int   ecnt;
    @(negedge clk);
    op0_vld = v0; op0_cls = c0; op1_vld = v1; op1_cls = c1; pipes_rdy = rdy;
    e.ef = 0; e.ec = 0; e.of = 0; e.oc = 0; e.tag = tag; ecnt = 0;
    if (rdy && v0) begin
      ecnt = 1;
      if (is_odd(c0)) begin e.of = 1; e.oc = c0; end
      else            begin e.ef = 1; e.ec = c0; end
      if (v1 && (is_odd(c1) != is_odd(c0))) begin
        ecnt = 2;
        if (is_odd(c1)) begin e.of = 1; e.oc = c1; end
        else            begin e.ef = 1; e.ec = c1; end
      end
    end
    #1;
    check({tag, " take_cnt"}, int'(take_cnt), ecnt);
    exp_q.push_back(e);
  endtask

  // monitor: compare registered outputs mid-high after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " even_fire R8"}, int'(even_fire), int'(e.ef));
        check({e.tag, " even_cls R8"},  int'(even_cls),  int'(e.ec));
        check({e.tag, " odd_fire R8"},  int'(odd_fire),  int'(e.of));
        check({e.tag, " odd_cls R8"},   int'(odd_cls),   int'(e.oc));
      end
    end
  end

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R9: reset state, with a live split pair on the inputs
    op0_vld = 1; op0_cls = 4'd0; op1_vld = 1; op1_cls = 4'd5; pipes_rdy = 1;
    repeat (3) @(posedge clk);
    #5;
    check("R9 reset even_fire", int'(even_fire), 0);
    check("R9 reset odd_fire", int'(odd_fire), 0);
    check("R9 reset even_cls", int'(even_cls), 0);
    check("R9 reset odd_cls", int'(odd_cls), 0);
    @(negedge clk);
    op0_vld = 0; op1_vld = 0;
    rst_n = 1;
    @(posedge clk);
    #5;
    check("R9 post-reset even_fire", int'(even_fire), 0);
    check("R9 post-reset odd_fire", int'(odd_fire), 0);

    // R1 R2 R3 R4: every class pair, both valid, downstream ready
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        apply(1, 4'(a), 1, 4'(b), 1, "R1_R2_R3_R4 pair");

    // R3: split in both orders
    apply(1, 4'd1, 1, 4'd7, 1, "R3 even-then-odd");
    apply(1, 4'd8, 1, 4'd2, 1, "R3 odd-then-even");
    // R4: same-pipe pair, then the held younger one becomes the older slot
    apply(1, 4'd0, 1, 4'd3, 1, "R4 even conflict");
    apply(1, 4'd3, 1, 4'd9, 1, "R4 held younger advances");
    apply(1, 4'd4, 1, 4'd9, 1, "R4 odd conflict");
    // R5: stall with every pattern, then the same pair issues
    for (int a = 0; a < 16; a += 3)
      apply(1, 4'(a), 1, 4'(15 - a), 0, "R5 stall");
    apply(1, 4'd2, 1, 4'd6, 0, "R5 stall split");
    apply(1, 4'd2, 1, 4'd6, 1, "R5 release split");
    // R6: older slot empty, younger slot valid
    apply(0, 4'd1, 1, 4'd5, 1, "R6 younger only");
    apply(0, 4'd6, 1, 4'd0, 1, "R6 younger only b");
    // R7: only the older slot valid
    apply(1, 4'd2, 0, 4'd8, 1, "R7 older even alone");
    apply(1, 4'd9, 0, 4'd1, 1, "R7 older odd alone");
    // mixed sequence
    for (int i = 0; i < 300; i++)
      apply(1'((i * 7) % 5 != 0), 4'((i * 11) % 16), 1'((i * 3) % 4 != 0),
            4'((i * 5 + 3) % 16), 1'(i % 6 != 0), "R3_R4_R5_R6_R7 mixed");
    apply(0, 4'd0, 0, 4'd0, 1, "R8 idle drain");
    @(posedge clk);
    #6;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule